// File: doc/BRIEF.md
# Partitioned Multi-Channel Byte FIFO Manager

This block keeps six byte-wide FIFOs in one shared single-port RAM of 1024 bytes. The six queues serve the receive and transmit directions of two bearer channels and one signalling channel. Each FIFO gets a depth in 4-byte units from its configuration field. The FIFOs are laid out back to back in channel order, so the base of a channel is the sum of the depths of the channels before it. Each channel has a push port and a pop port. A round-robin arbiter grants one RAM access per clock across all twelve ports.

Each FIFO reports full and empty, and each of these can be inverted per channel. It also reports near-full and near-empty at a fixed 8-byte margin. Sticky overwrite and under-read flags record a push into a full FIFO and a pop from an empty one. A per-channel clear empties one FIFO without draining it.

A controller state machine has three states. FLUSH empties every FIFO. RUN serves all ports. HALT serves pops only and blocks pushes, because the configured depths exceed the RAM. Reset enters FLUSH. FLUSH stays in FLUSH while the configuration is still changing. Otherwise it goes to HALT when the depths overflow the RAM, and to RUN when they fit. RUN and HALT both return to FLUSH on any configuration change.

Top module: `fifo_partition_mgr`

## Requirements
- R1: `cfg_depth` holds six 9-bit depth fields in 4-byte units, with channel i at bits [9i+8:9i]. Each FIFO returns its bytes in push order, wraps correctly, and never disturbs another channel's data.
- R2: The internal full condition is stored == depth and the internal empty condition is stored == 0. `full_flag[i]` and `empty_flag[i]` output these conditions XORed with `cfg_full_inv[i]` and `cfg_empty_inv[i]`.
- R3: `nfull_flag[i]` is 1 when depth − stored ≤ 8. `nempty_flag[i]` is 1 when stored ≤ 8.
- R4: A push to a full FIFO is acknowledged but its byte is dropped. It sets `ovw_flag[i]`, which stays set until that channel is cleared or flushed.
- R5: A pop from an empty FIFO is acknowledged and returns data 0 with `pop_valid`. It sets `udr_flag[i]`, which is sticky in the same way as `ovw_flag`.
- R6: `pop_valid[i]` and `pop_data` appear in the cycle after `pop_ack[i]`.
- R7: While `clr[i]` is high, channel i gets no acknowledge. On the next cycle channel i is empty and its sticky flags are 0.
- R8: `cfg_err` is 1 when the depth fields sum to more than 256 units. A sum of exactly 256 units is accepted. While `cfg_err` is 1, no push is acknowledged, but pops still complete.
- R9: Any change of `cfg_depth` empties all six FIFOs.
- R10: At most one acknowledge is given per cycle, and only to a requesting port. Six continuously requesting ports are each served exactly once in six cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_depth | input | 54 | Six depth fields, 4-byte units |
| cfg_full_inv | input | 6 | Per-channel full flag inversion |
| cfg_empty_inv | input | 6 | Per-channel empty flag inversion |
| clr | input | 6 | Per-channel clear |
| push_req | input | 6 | Push request, held until acknowledged |
| push_data | input | 48 | Push byte, channel i at bits [8i+7:8i] |
| push_ack | output | 6 | Push accepted this cycle |
| pop_req | input | 6 | Pop request, held until acknowledged |
| pop_ack | output | 6 | Pop accepted this cycle |
| pop_valid | output | 6 | Pop data valid, one cycle after acknowledge |
| pop_data | output | 8 | Popped byte |
| full_flag | output | 6 | Full (polarity applied) |
| empty_flag | output | 6 | Empty (polarity applied) |
| nfull_flag | output | 6 | Eight or fewer free bytes |
| nempty_flag | output | 6 | Eight or fewer stored bytes |
| ovw_flag | output | 6 | Sticky overwrite |
| udr_flag | output | 6 | Sticky under-read |
| cfg_err | output | 1 | Depths exceed the RAM |

## Verification
Each channel is filled byte by byte from empty to full and then past full, and all flags are compared with arithmetic from the stored count at every step. All channels are then drained while distinct per-channel data values are checked, which separates a wrong base offset from a wrong pointer. A short cycle of push 3, pop 3 on a 4-byte FIFO forces repeated pointer wraparound. Further tests cover polarity masks on a mixed-fill state, clearing with a push held pending, and a configuration change that flushes all channels. All six push ports are then driven at once to expose unfair or double grants. Finally, depth sums of 300 and exactly 256 units mark the edge of the RAM budget.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    typedef enum logic [1:0] {
        ST_FLUSH = 2'd0,
        ST_RUN   = 2'd1,
        ST_HALT  = 2'd2
    } fpm_state_e;
endpackage

// File: rtl/fpm_rr_arb.sv
module fpm_rr_arb #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    localparam int IW = $clog2(N);

    logic [IW-1:0] ptr_q;
    logic [IW-1:0] gidx;
    logic          found;

    always_comb begin
        int j;
        gnt   = '0;
        gidx  = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                found  = 1'b1;
                gnt[j] = 1'b1;
                gidx   = IW'(j);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (found) begin
            ptr_q <= (gidx == IW'(N - 1)) ? '0 : gidx + 1'b1;
        end
    end
endmodule

// File: rtl/fpm_chan_ctrl.sv
module fpm_chan_ctrl #(
    parameter int AW       = 10,
    parameter int NEAR_LVL = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        flush,
    input  logic        clr,
    input  logic [AW:0] depth_b,
    input  logic        do_push,
    input  logic        do_pop,
    output logic        wr_ok,
    output logic        rd_ok,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic        is_full,
    output logic        is_empty,
    output logic        near_full,
    output logic        near_empty,
    output logic        ovw,
    output logic        udr
);
    localparam int CW = AW + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_idx;

    assign last_idx   = depth_b - 1'b1;
    assign is_full    = (cnt_q == depth_b);
    assign is_empty   = (cnt_q == '0);
    assign near_full  = ((depth_b - cnt_q) <= CW'(NEAR_LVL));
    assign near_empty = (cnt_q <= CW'(NEAR_LVL));
    assign wr_ok      = do_push && !is_full;
    assign rd_ok      = do_pop && !is_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            ovw    <= 1'b0;
            udr    <= 1'b0;
        end else if (flush || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            ovw    <= 1'b0;
            udr    <= 1'b0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= ({1'b0, wr_ptr} == last_idx) ? '0 : wr_ptr + 1'b1;
                cnt_q  <= cnt_q + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr <= ({1'b0, rd_ptr} == last_idx) ? '0 : rd_ptr + 1'b1;
                cnt_q  <= cnt_q - 1'b1;
            end
            if (do_push && is_full) ovw <= 1'b1;
            if (do_pop && is_empty) udr <= 1'b1;
        end
    end
endmodule

// File: rtl/fpm_byte_ram.sv
module fpm_byte_ram #(
    parameter int WORDS  = 1024,
    parameter int AW     = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata <= mem[addr];
    end
endmodule

// File: rtl/fifo_partition_mgr.sv
module fifo_partition_mgr
    import fpm_pkg::*;
#(
    parameter int NUM_CH     = 6,
    parameter int RAM_BYTES  = 1024,
    parameter int STEP_BYTES = 4,
    parameter int NEAR_LVL   = 8,
    parameter int DATA_W     = 8,
    parameter int DEPTH_W    = $clog2(RAM_BYTES / STEP_BYTES) + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH*DEPTH_W-1:0]  cfg_depth,
    input  logic [NUM_CH-1:0]          cfg_full_inv,
    input  logic [NUM_CH-1:0]          cfg_empty_inv,
    input  logic [NUM_CH-1:0]          clr,
    input  logic [NUM_CH-1:0]          push_req,
    input  logic [NUM_CH*DATA_W-1:0]   push_data,
    output logic [NUM_CH-1:0]          push_ack,
    input  logic [NUM_CH-1:0]          pop_req,
    output logic [NUM_CH-1:0]          pop_ack,
    output logic [NUM_CH-1:0]          pop_valid,
    output logic [DATA_W-1:0]          pop_data,
    output logic [NUM_CH-1:0]          full_flag,
    output logic [NUM_CH-1:0]          empty_flag,
    output logic [NUM_CH-1:0]          nfull_flag,
    output logic [NUM_CH-1:0]          nempty_flag,
    output logic [NUM_CH-1:0]          ovw_flag,
    output logic [NUM_CH-1:0]          udr_flag,
    output logic                       cfg_err
);
    localparam int AW      = $clog2(RAM_BYTES);
    localparam int CNT_W   = AW + 1;
    localparam int STEP_SH = $clog2(STEP_BYTES);
    localparam int SUM_W   = DEPTH_W + $clog2(NUM_CH) + 1;
    localparam int BASE_W  = SUM_W + STEP_SH;
    localparam int LIMIT_U = RAM_BYTES / STEP_BYTES;
    localparam int NREQ    = 2 * NUM_CH;

    fpm_state_e state_q, state_d;
    logic [NUM_CH*DEPTH_W-1:0] cfg_q;
    logic                      cfg_chg;
    logic                      flush;
    logic                      push_en;
    logic                      pop_en;

    logic [SUM_W-1:0]  base_u [NUM_CH];
    logic [BASE_W-1:0] base_b [NUM_CH];
    logic [SUM_W-1:0]  sum_u;

    logic [NREQ-1:0]   req;
    logic [NREQ-1:0]   gnt;
    logic [NUM_CH-1:0] wr_ok, rd_ok, full_raw, empty_raw;
    logic [AW-1:0]     wr_ptr [NUM_CH];
    logic [AW-1:0]     rd_ptr [NUM_CH];

    logic              ram_we, ram_re;
    logic [AW-1:0]     ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_q;
    logic              rd_hit_q;

    // configuration snapshot and layout
    assign cfg_chg = (cfg_depth != cfg_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_depth;
    end

    always_comb begin
        sum_u = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            base_u[i] = sum_u;
            base_b[i] = BASE_W'(sum_u) << STEP_SH;
            sum_u     = sum_u + SUM_W'(cfg_q[i*DEPTH_W +: DEPTH_W]);
        end
    end

    assign cfg_err = (sum_u > SUM_W'(LIMIT_U));

    // controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLUSH;
        else        state_q <= state_d;
    end

    // controller: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLUSH: begin
                if (!cfg_chg) state_d = cfg_err ? ST_HALT : ST_RUN;
            end
            ST_RUN: begin
                if (cfg_chg) state_d = ST_FLUSH;
            end
            ST_HALT: begin
                if (cfg_chg) state_d = ST_FLUSH;
            end
            default: state_d = ST_FLUSH;
        endcase
    end

    // controller: outputs
    always_comb begin
        flush   = 1'b0;
        push_en = 1'b0;
        pop_en  = 1'b0;
        unique case (state_q)
            ST_FLUSH: flush = 1'b1;
            ST_RUN: begin
                push_en = !cfg_chg && !cfg_err;
                pop_en  = !cfg_chg;
            end
            ST_HALT:  pop_en = !cfg_chg;
            default:  flush = 1'b1;
        endcase
    end

    // arbitration over push ports then pop ports
    assign req = {pop_req & ~clr & {NUM_CH{pop_en}},
                  push_req & ~clr & {NUM_CH{push_en}}};

    fpm_rr_arb #(.N(NREQ)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    assign push_ack = gnt[NUM_CH-1:0];
    assign pop_ack  = gnt[NREQ-1:NUM_CH];

    // per-channel pointers and flags
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [CNT_W-1:0] depth_b;
        assign depth_b = CNT_W'(cfg_q[g*DEPTH_W +: DEPTH_W]) << STEP_SH;

        fpm_chan_ctrl #(.AW(AW), .NEAR_LVL(NEAR_LVL)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .clr        (clr[g]),
            .depth_b    (depth_b),
            .do_push    (push_ack[g]),
            .do_pop     (pop_ack[g]),
            .wr_ok      (wr_ok[g]),
            .rd_ok      (rd_ok[g]),
            .wr_ptr     (wr_ptr[g]),
            .rd_ptr     (rd_ptr[g]),
            .is_full    (full_raw[g]),
            .is_empty   (empty_raw[g]),
            .near_full  (nfull_flag[g]),
            .near_empty (nempty_flag[g]),
            .ovw        (ovw_flag[g]),
            .udr        (udr_flag[g])
        );
    end

    assign full_flag  = full_raw ^ cfg_full_inv;
    assign empty_flag = empty_raw ^ cfg_empty_inv;

    // shared RAM port mux
    always_comb begin
        ram_we    = 1'b0;
        ram_re    = 1'b0;
        ram_addr  = '0;
        ram_wdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_ok[i]) begin
                ram_we    = 1'b1;
                ram_addr  = AW'(base_b[i]) + wr_ptr[i];
                ram_wdata = push_data[i*DATA_W +: DATA_W];
            end
            if (rd_ok[i]) begin
                ram_re   = 1'b1;
                ram_addr = AW'(base_b[i]) + rd_ptr[i];
            end
        end
    end

    fpm_byte_ram #(.WORDS(RAM_BYTES), .AW(AW), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .re    (ram_re),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_valid <= '0;
            rd_hit_q  <= 1'b0;
        end else begin
            pop_valid <= pop_ack;
            rd_hit_q  <= ram_re;
        end
    end

    assign pop_data = rd_hit_q ? ram_q : '0;
endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
    parameter int NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] push_req,
    input logic [NUM_CH-1:0] pop_req,
    input logic [NUM_CH-1:0] push_ack,
    input logic [NUM_CH-1:0] pop_ack,
    input logic [NUM_CH-1:0] pop_valid,
    input logic [NUM_CH-1:0] clr,
    input logic [NUM_CH-1:0] empty_raw,
    input logic [NUM_CH-1:0] ovw_flag,
    input logic              flush,
    input logic              cfg_err
);
    // R10
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_ack, pop_ack}));

    // R10
    ack_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((push_ack & ~push_req) == '0) && ((pop_ack & ~pop_req) == '0));

    // R8
    cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (push_ack == '0));

    // R6
    pop_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pop_valid == $past(pop_ack)));

    // R7
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr != '0) |=> ((empty_raw & $past(clr)) == $past(clr)));

    // R4
    ovw_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> ((ovw_flag & $past(ovw_flag & ~clr)) == $past(ovw_flag & ~clr)));
endmodule

bind fifo_partition_mgr fpm_checker #(.NUM_CH(NUM_CH)) u_fpm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .push_ack  (push_ack),
    .pop_ack   (pop_ack),
    .pop_valid (pop_valid),
    .clr       (clr),
    .empty_raw (empty_raw),
    .ovw_flag  (ovw_flag),
    .flush     (flush),
    .cfg_err   (cfg_err)
);

// File: tb/fifo_partition_mgr_bench.sv
module fifo_partition_mgr_bench;
    localparam int NCH = 6;
    localparam int DW  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*DW-1:0] cfg_depth = '0;
    logic [NCH-1:0]    cfg_full_inv = '0;
    logic [NCH-1:0]    cfg_empty_inv = '0;
    logic [NCH-1:0]    clr = '0;
    logic [NCH-1:0]    push_req = '0;
    logic [NCH*8-1:0]  push_data = '0;
    logic [NCH-1:0]    push_ack, pop_ack, pop_valid;
    logic [NCH-1:0]    pop_req = '0;
    logic [7:0]        pop_data;
    logic [NCH-1:0]    full_flag, empty_flag, nfull_flag, nempty_flag, ovw_flag, udr_flag;
    logic              cfg_err;

    int checks = 0;
    int errors = 0;
    int dep [NCH];
    bit done = 0;

    always #4 clk = ~clk;

    fifo_partition_mgr u_fifo_partition_mgr (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth),
        .cfg_full_inv(cfg_full_inv), .cfg_empty_inv(cfg_empty_inv), .clr(clr),
        .push_req(push_req), .push_data(push_data), .push_ack(push_ack),
        .pop_req(pop_req), .pop_ack(pop_ack), .pop_valid(pop_valid), .pop_data(pop_data),
        .full_flag(full_flag), .empty_flag(empty_flag), .nfull_flag(nfull_flag),
        .nempty_flag(nempty_flag), .ovw_flag(ovw_flag), .udr_flag(udr_flag),
        .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input int d [NCH]);
        for (int i = 0; i < NCH; i++) begin
            dep[i] = d[i] * 4;
            cfg_depth[i*DW +: DW] = DW'(d[i]);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic check_flags(input int ch, input int cnt, input string tag);
        int dp = dep[ch];
        chk({tag, " R2 full"},   int'(full_flag[ch]),  ((cnt == dp) ? 1 : 0) ^ int'(cfg_full_inv[ch]));
        chk({tag, " R2 empty"},  int'(empty_flag[ch]), ((cnt == 0) ? 1 : 0) ^ int'(cfg_empty_inv[ch]));
        chk({tag, " R3 nfull"},  int'(nfull_flag[ch]), ((dp - cnt) <= 8) ? 1 : 0);
        chk({tag, " R3 nempty"}, int'(nempty_flag[ch]), (cnt <= 8) ? 1 : 0);
    endtask

    task automatic push_one(input int ch, input int d, output bit ok);
        int t = 0;
        ok = 0;
        push_data[ch*8 +: 8] = 8'(d);
        push_req[ch] = 1'b1;
        while (t < 12 && !ok) begin
            #1;
            if (push_ack[ch]) ok = 1;
            @(negedge clk);
            t++;
        end
        push_req[ch] = 1'b0;
    endtask

    task automatic pop_one(input int ch, output int d, output int v);
        int t = 0;
        bit ok = 0;
        pop_req[ch] = 1'b1;
        while (t < 12 && !ok) begin
            #1;
            if (pop_ack[ch]) ok = 1;
            @(negedge clk);
            t++;
        end
        pop_req[ch] = 1'b0;
        d = int'(pop_data);
        v = ok ? int'(pop_valid[ch]) : 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ok;
        int d, v, acks;
        int cnt_ack [NCH];
        set_cfg('{2, 1, 3, 2, 1, 4});
        // reset state
        chk("reset R2 empty", int'(empty_flag), 6'h3f);
        chk("reset R6 pop_valid", int'(pop_valid), 0);
        chk("reset R10 ack", int'({push_ack, pop_ack}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 cfg_err low", int'(cfg_err), 0);

        // fill sweep with overflow
        for (int ch = 0; ch < NCH; ch++) begin
            for (int i = 0; i <= dep[ch]; i++) begin
                check_flags(ch, i, "fill");
                if (i < dep[ch]) push_one(ch, ch * 32 + i, ok);
            end
            push_one(ch, 8'hEE, ok);
            chk("R4 push to full acked", int'(ok), 1);
            chk("R4 ovw set", int'(ovw_flag[ch]), 1);
            check_flags(ch, dep[ch], "R4 count unchanged");
        end

        // drain sweep with underflow
        for (int ch = 0; ch < NCH; ch++) begin
            for (int i = 0; i < dep[ch]; i++) begin
                pop_one(ch, d, v);
                chk("R6 pop_valid", v, 1);
                chk("R1 data order/isolation", d, ch * 32 + i);
                check_flags(ch, dep[ch] - 1 - i, "drain");
            end
            chk("R4 ovw sticky", int'(ovw_flag[ch]), 1);
            pop_one(ch, d, v);
            chk("R5 underread valid", v, 1);
            chk("R5 underread data", d, 0);
            chk("R5 udr set", int'(udr_flag[ch]), 1);
        end

        // wraparound on a 4-byte FIFO
        for (int r = 0; r < 5; r++) begin
            for (int k = 0; k < 3; k++) push_one(1, 100 + r * 8 + k, ok);
            for (int k = 0; k < 3; k++) begin
                pop_one(1, d, v);
                chk("R1 wrap data", d, 100 + r * 8 + k);
            end
        end

        // clear with pending push
        push_one(0, 7, ok);
        push_one(0, 8, ok);
        push_req[0] = 1'b1;
        clr[0] = 1'b1;
        #1;
        chk("R7 no ack during clr", int'(push_ack[0]), 0);
        @(negedge clk);
        clr[0] = 1'b0;
        push_req[0] = 1'b0;
        check_flags(0, 0, "R7 cleared");
        chk("R7 ovw cleared", int'(ovw_flag[0]), 0);
        chk("R7 udr cleared", int'(udr_flag[0]), 0);
        push_one(0, 8'h5A, ok);
        pop_one(0, d, v);
        chk("R7 data after clr", d, 8'h5A);

        // polarity
        push_one(3, 1, ok);
        push_one(3, 2, ok);
        cfg_full_inv  = 6'b101010;
        cfg_empty_inv = 6'b010101;
        @(negedge clk);
        for (int ch = 0; ch < NCH; ch++) check_flags(ch, (ch == 3) ? 2 : 0, "polarity");
        cfg_full_inv  = '0;
        cfg_empty_inv = '0;

        // config change flush
        set_cfg('{4, 4, 4, 4, 4, 4});
        for (int ch = 0; ch < NCH; ch++) check_flags(ch, 0, "R9 flush");
        chk("R9 sticky cleared", int'(udr_flag), 0);

        // all six push ports at once
        for (int ch = 0; ch < NCH; ch++) begin
            cnt_ack[ch] = 0;
            push_data[ch*8 +: 8] = 8'(200 + ch);
        end
        push_req = '1;
        for (int c = 0; c < NCH; c++) begin
            #1;
            chk("R10 one ack per cycle", $countones(push_ack), 1);
            for (int ch = 0; ch < NCH; ch++) if (push_ack[ch]) cnt_ack[ch]++;
            @(negedge clk);
        end
        push_req = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            chk("R10 each served once", cnt_ack[ch], 1);
            pop_one(ch, d, v);
            chk("R10 data", d, 200 + ch);
        end

        // budget overflow
        set_cfg('{50, 50, 50, 50, 50, 50});
        chk("R8 cfg_err high", int'(cfg_err), 1);
        push_one(2, 9, ok);
        chk("R8 push blocked", int'(ok), 0);
        pop_one(2, d, v);
        chk("R8 pop still served", v, 1);
        chk("R5 zero data in halt", d, 0);
        // exact budget
        set_cfg('{43, 43, 43, 43, 43, 41});
        chk("R8 exact fit", int'(cfg_err), 0);
        push_one(5, 77, ok);
        chk("R8 push after fit", int'(ok), 1);
        pop_one(5, d, v);
        chk("R1 last channel data", d, 77);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule